// File: doc/BRIEF.md
# Digital Bit Clock Recovery Loop

This block derives a data bit clock from a fast system clock by dividing it by 64. When phase tracking is on, each selected reference edge is compared with the middle of the divider's count, and the divider is pushed forward or held back by 1/32 of a bit period so that its midpoint settles onto the reference. The reference can be transitions of the received data, rising edges of an external reference clock, or rising edges of an external strobe. Every reference input is first brought into the system clock domain by a synchronizer.

With tracking off, the divider counts freely and the bit clock is a plain divided copy of the system clock. A second, independent divide-by-64 counter provides an internal encode clock. Two output selectors then pick the decode clock (recovered bit clock or an externally supplied receive clock) and the encode clock (external transmit clock, the internal encode divider, or the decode clock). The configuration inputs are static control levels that a register elsewhere drives.

Top module: `bclk_rec`

## Requirements
- R1: After reset the bit counter is 0, so `rec_clk` is low for the first 32 system clocks after reset release and high for the next 32; the internal encode divider starts the same way.
- R2: With `trk_en` low the bit counter advances by exactly one every clock, giving `rec_clk` a period of 64 clocks with 32 high and 32 low, whatever the reference inputs do.
- R3: `ref_ext`=0 selects both rising and falling transitions of `rx_data` as the reference; `ref_ext`=1 with `ref_stb_sel`=0 selects rising edges of `ref_clk_in`; `ref_ext`=1 with `ref_stb_sel`=1 selects rising edges of `ref_stb_in`; edges on the two unselected inputs never change the counter.
- R4: A reference input level sampled at clock edge k produces a detected edge that is compared with the count held between edges k+1 and k+2; if that count is above 32+DEADBAND the counter is retarded by one step (next count = count-1 instead of count+1), if below 32-DEADBAND it is advanced by one step (next count = count+3); one step is 2 counts, 1/32 of the bit period, and `rec_clk` is high for counts 32 to 63.
- R5: A detected edge arriving while the count lies from 32-DEADBAND to 32+DEADBAND inclusive (31 to 33 with the default DEADBAND of 1) causes no correction.
- R6: After a correction, further detected edges are ignored until the counter wraps from 63 to 0, so the counter moves by at most one step per bit period.
- R7: `dec_rec_sel`=1 drives `dec_clk` from the recovered bit clock; `dec_rec_sel`=0 passes `rx_clk_in`.
- R8: `enc_sel` picks the encode clock: bit 0 low selects `tx_clk_in` regardless of bit 1; value 2'b01 selects the internal encode divider; value 2'b11 selects `dec_clk`.
- R9: The internal encode divider counts freely by one per clock with a 64-clock period, unaffected by tracking and by reference edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 1 | Received data, asynchronous |
| ref_clk_in | input | 1 | External reference clock, asynchronous |
| ref_stb_in | input | 1 | External reference strobe, asynchronous |
| rx_clk_in | input | 1 | Externally supplied receive clock |
| tx_clk_in | input | 1 | Externally supplied transmit clock |
| trk_en | input | 1 | Enables phase tracking |
| ref_ext | input | 1 | 0: track data transitions, 1: track an external reference |
| ref_stb_sel | input | 1 | With an external reference, 0: clock, 1: strobe |
| dec_rec_sel | input | 1 | Decode clock source select |
| enc_sel | input | 2 | Encode clock source select |
| rec_clk | output | 1 | Recovered bit clock |
| dec_clk | output | 1 | Selected decode clock |
| enc_clk | output | 1 | Selected encode clock |

## Verification
The assertions watch, on every cycle, that the bit counter only ever moves by one count, one count plus a step or one count minus a step, that it moves by one when tracking is off or when a detected edge falls in the dead band, that no bit period holds more than one correction, that the internal encode divider never deviates, and that the decode and encode selectors route the right source. Only the bench scenarios can show the end-to-end effect: which of the three inputs is heard under each reference setting, the synchronizer latency that decides which count an edge is compared with, the direction of each correction seen as a 62, 64 or 66 clock stretch of the bit clock, and the dead-band boundaries at both sides of the midpoint.

// File: rtl/br_pkg.sv
package br_pkg;

   typedef enum logic [1:0] {
      PH_HOLD = 2'b00,
      PH_ADV  = 2'b01,
      PH_RET  = 2'b10
   } ph_cmd_e;

   typedef enum logic [1:0] {
      ENC_EXT_A    = 2'b00,
      ENC_INT      = 2'b01,
      ENC_EXT_B    = 2'b10,
      ENC_FROM_DEC = 2'b11
   } enc_src_e;

   localparam int NUM_REF = 3;
   localparam int REF_DATA = 0;
   localparam int REF_CLK  = 1;
   localparam int REF_STB  = 2;

endpackage

// File: rtl/br_sync_edge.sv
module br_sync_edge #(
   parameter int SYNC_N     = 2,
   parameter bit BOTH_EDGES = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic edge_o
);

   generate
      if (SYNC_N < 2) begin : g_bad_sync
         $error("br_sync_edge: SYNC_N must be at least 2");
      end
   endgenerate

   logic [SYNC_N-1:0] shreg;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         last  <= 1'b0;
      end else begin
         shreg <= {shreg[SYNC_N-2:0], din};
         last  <= shreg[SYNC_N-1];
      end
   end

   generate
      if (BOTH_EDGES) begin : g_any
         assign edge_o = shreg[SYNC_N-1] ^ last;
      end else begin : g_rise
         assign edge_o = shreg[SYNC_N-1] & ~last;
      end
   endgenerate

endmodule

// File: rtl/br_bit_ctr.sv
module br_bit_ctr
   import br_pkg::*;
#(
   parameter int DIV  = 64,
   parameter int STEP = 2,
   localparam int CW  = $clog2(DIV)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  ph_cmd_e       cmd,
   output logic [CW-1:0] cnt
);

   generate
      if ((1 << CW) != DIV) begin : g_bad_div
         $error("br_bit_ctr: DIV must be a power of two");
      end
      if (STEP < 1 || STEP >= DIV / 4) begin : g_bad_step
         $error("br_bit_ctr: STEP out of range");
      end
   endgenerate

   localparam logic [CW-1:0] INC_ONE  = CW'(1);
   localparam logic [CW-1:0] INC_FWD  = CW'(1 + STEP);
   localparam logic [CW-1:0] DEC_BACK = CW'(STEP - 1);

   logic [CW-1:0] cnt_nxt;

   always_comb begin
      unique case (cmd)
         PH_ADV:  cnt_nxt = cnt + INC_FWD;
         PH_RET:  cnt_nxt = cnt - DEC_BACK;
         default: cnt_nxt = cnt + INC_ONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end

endmodule

// File: rtl/br_phase_det.sv
module br_phase_det
   import br_pkg::*;
#(
   parameter int DIV      = 64,
   parameter int STEP     = 2,
   parameter int DEADBAND = 1,
   localparam int CW      = $clog2(DIV)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trk_en,
   input  logic          ref_edge,
   input  logic [CW-1:0] cnt,
   output ph_cmd_e       cmd_o
);

   localparam int MID = DIV / 2;

   generate
      if (DEADBAND < 0 || DEADBAND + STEP >= MID) begin : g_bad_band
         $error("br_phase_det: DEADBAND out of range");
      end
   endgenerate

   localparam logic [CW-1:0] HI_LIM  = CW'(MID + DEADBAND);
   localparam logic [CW-1:0] LO_LIM  = CW'(MID - DEADBAND);
   localparam logic [CW-1:0] CNT_TOP = CW'(DIV - 1);

   logic fired;
   logic wrap;

   always_comb begin
      cmd_o = PH_HOLD;
      if (trk_en && ref_edge && !fired) begin
         if (cnt > HI_LIM)      cmd_o = PH_RET;
         else if (cnt < LO_LIM) cmd_o = PH_ADV;
      end
   end

   assign wrap = (cmd_o == PH_HOLD) && (cnt == CNT_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 fired <= 1'b0;
      else if (cmd_o != PH_HOLD)  fired <= 1'b1;
      else if (wrap)              fired <= 1'b0;
   end

endmodule

// File: rtl/br_clk_sel.sv
module br_clk_sel
   import br_pkg::*;
(
   input  logic       rec_bit,
   input  logic       int_bit,
   input  logic       rx_clk_in,
   input  logic       tx_clk_in,
   input  logic       dec_rec_sel,
   input  logic [1:0] enc_sel,
   output logic       dec_clk,
   output logic       enc_clk
);

   assign dec_clk = dec_rec_sel ? rec_bit : rx_clk_in;

   always_comb begin
      unique case (enc_src_e'(enc_sel))
         ENC_INT:      enc_clk = int_bit;
         ENC_FROM_DEC: enc_clk = dec_clk;
         default:      enc_clk = tx_clk_in;
      endcase
   end

endmodule

// File: rtl/bclk_rec.sv
module bclk_rec
   import br_pkg::*;
#(
   parameter int DIV         = 64,
   parameter int PHASE_STEPS = 32,
   parameter int DEADBAND    = 1,
   parameter int SYNC_N      = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_data,
   input  logic       ref_clk_in,
   input  logic       ref_stb_in,
   input  logic       rx_clk_in,
   input  logic       tx_clk_in,
   input  logic       trk_en,
   input  logic       ref_ext,
   input  logic       ref_stb_sel,
   input  logic       dec_rec_sel,
   input  logic [1:0] enc_sel,
   output logic       rec_clk,
   output logic       dec_clk,
   output logic       enc_clk
);

   localparam int CW   = $clog2(DIV);
   localparam int STEP = DIV / PHASE_STEPS;

   generate
      if (PHASE_STEPS < 2 || (DIV % PHASE_STEPS) != 0) begin : g_bad_steps
         $error("bclk_rec: DIV must be a multiple of PHASE_STEPS");
      end
   endgenerate

   logic [NUM_REF-1:0] ref_raw;
   logic [NUM_REF-1:0] ref_pulse;
   logic               ref_edge;
   logic [CW-1:0]      bit_cnt;
   logic [CW-1:0]      int_cnt;
   ph_cmd_e            ph_cmd;

   assign ref_raw[REF_DATA] = rx_data;
   assign ref_raw[REF_CLK]  = ref_clk_in;
   assign ref_raw[REF_STB]  = ref_stb_in;

   generate
      for (genvar g = 0; g < NUM_REF; g++) begin : g_ref
         br_sync_edge #(
            .SYNC_N     (SYNC_N),
            .BOTH_EDGES (g == REF_DATA)
         ) u_sync_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .din    (ref_raw[g]),
            .edge_o (ref_pulse[g])
         );
      end
   endgenerate

   always_comb begin
      if (!ref_ext)        ref_edge = ref_pulse[REF_DATA];
      else if (ref_stb_sel) ref_edge = ref_pulse[REF_STB];
      else                 ref_edge = ref_pulse[REF_CLK];
   end

   br_phase_det #(
      .DIV      (DIV),
      .STEP     (STEP),
      .DEADBAND (DEADBAND)
   ) u_phase_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .trk_en   (trk_en),
      .ref_edge (ref_edge),
      .cnt      (bit_cnt),
      .cmd_o    (ph_cmd)
   );

   br_bit_ctr #(
      .DIV  (DIV),
      .STEP (STEP)
   ) u_bit_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd   (ph_cmd),
      .cnt   (bit_cnt)
   );

   br_bit_ctr #(
      .DIV  (DIV),
      .STEP (STEP)
   ) u_int_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd   (PH_HOLD),
      .cnt   (int_cnt)
   );

   assign rec_clk = bit_cnt[CW-1];

   br_clk_sel u_clk_sel (
      .rec_bit     (rec_clk),
      .int_bit     (int_cnt[CW-1]),
      .rx_clk_in   (rx_clk_in),
      .tx_clk_in   (tx_clk_in),
      .dec_rec_sel (dec_rec_sel),
      .enc_sel     (enc_sel),
      .dec_clk     (dec_clk),
      .enc_clk     (enc_clk)
   );

endmodule

// File: rtl/br_chk.sv
module br_chk #(
   parameter int DIV      = 64,
   parameter int STEP     = 2,
   parameter int DEADBAND = 1,
   localparam int CW      = $clog2(DIV)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          trk_en,
   input logic          ref_edge,
   input logic [CW-1:0] cnt,
   input logic [CW-1:0] int_cnt,
   input logic          dec_rec_sel,
   input logic          dec_clk,
   input logic [1:0]    enc_sel,
   input logic          enc_clk
);

   localparam int MID = DIV / 2;
   localparam logic [CW-1:0] LO_LIM  = CW'(MID - DEADBAND);
   localparam logic [CW-1:0] HI_LIM  = CW'(MID + DEADBAND);
   localparam logic [CW-1:0] CNT_TOP = CW'(DIV - 1);

   logic [CW-1:0] prev_cnt;
   logic          seen;
   logic [1:0]    corr_in_period;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_cnt       <= '0;
         seen           <= 1'b0;
         corr_in_period <= '0;
      end else begin
         prev_cnt <= cnt;
         seen     <= 1'b1;
         if (seen) begin
            if (prev_cnt == CNT_TOP && cnt == '0)
               corr_in_period <= '0;
            else if (cnt != CW'(prev_cnt + CW'(1)) && corr_in_period != 2'd3)
               corr_in_period <= corr_in_period + 2'd1;
         end
      end
   end

   // R2: no tracking means a plain count
   p_free_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !trk_en |=> cnt == CW'($past(cnt) + CW'(1)));

   // R4: only the three legal moves
   p_step_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt == CW'($past(cnt) + CW'(1))) ||
               (cnt == CW'($past(cnt) + CW'(1 + STEP))) ||
               (cnt == CW'($past(cnt) - CW'(STEP - 1))));

   // R5: dead band edges leave the count alone
   p_dead_band_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_edge && cnt >= LO_LIM && cnt <= HI_LIM) |=> cnt == CW'($past(cnt) + CW'(1)));

   // R6: at most one correction between wraps
   p_one_per_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
      corr_in_period <= 2'd1);

   // R7: decode clock follows the recovered bit clock
   p_dec_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dec_rec_sel |-> dec_clk == cnt[CW-1]);

   // R8: encode clock routing
   p_enc_int_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_sel == 2'b01) |-> enc_clk == int_cnt[CW-1]);
   p_enc_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_sel == 2'b11) |-> enc_clk == dec_clk);

   // R9: internal encode divider never corrected
   p_int_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> int_cnt == CW'($past(int_cnt) + CW'(1)));

endmodule

bind bclk_rec br_chk #(
   .DIV      (DIV),
   .STEP     (STEP),
   .DEADBAND (DEADBAND)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .trk_en      (trk_en),
   .ref_edge    (ref_edge),
   .cnt         (bit_cnt),
   .int_cnt     (int_cnt),
   .dec_rec_sel (dec_rec_sel),
   .dec_clk     (dec_clk),
   .enc_sel     (enc_sel),
   .enc_clk     (enc_clk)
);

// File: tb/tb_bclk_rec.sv
module tb_bclk_rec;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_data = 1'b0, ref_clk_in = 1'b0, ref_stb_in = 1'b0;
   logic       rx_clk_in = 1'b0, tx_clk_in = 1'b0;
   logic       trk_en = 1'b0, ref_ext = 1'b0, ref_stb_sel = 1'b0, dec_rec_sel = 1'b1;
   logic [1:0] enc_sel = 2'b01;
   logic       rec_clk, dec_clk, enc_clk;

   int checks = 0;
   int bad = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   bclk_rec dut (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .ref_clk_in(ref_clk_in),
      .ref_stb_in(ref_stb_in), .rx_clk_in(rx_clk_in), .tx_clk_in(tx_clk_in),
      .trk_en(trk_en), .ref_ext(ref_ext), .ref_stb_sel(ref_stb_sel),
      .dec_rec_sel(dec_rec_sel), .enc_sel(enc_sel),
      .rec_clk(rec_clk), .dec_clk(dec_clk), .enc_clk(enc_clk)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit f_enc(input logic [1:0] sel, input bit tx, input bit dec, input bit ib);
      if (!sel[0]) return tx;
      return sel[1] ? dec : ib;
   endfunction

   // reference model built from the requirements
   int   m_cnt, m_int;
   bit   m_fired;
   logic [2:0] m_s1, m_s2, m_pv;
   logic m_e;

   always_comb begin
      if (!ref_ext)         m_e = m_s2[0] ^ m_pv[0];
      else if (ref_stb_sel) m_e = m_s2[2] & ~m_pv[2];
      else                  m_e = m_s2[1] & ~m_pv[1];
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= 0; m_int <= 0; m_fired <= 0;
         m_s1 <= '0; m_s2 <= '0; m_pv <= '0;
      end else begin
         m_s1 <= {ref_stb_in, ref_clk_in, rx_data};
         m_s2 <= m_s1;
         m_pv <= m_s2;
         m_int <= (m_int + 1) % 64;
         if (trk_en && m_e && !m_fired && m_cnt > 33) begin
            m_cnt <= m_cnt - 1; m_fired <= 1;
         end else if (trk_en && m_e && !m_fired && m_cnt < 31) begin
            m_cnt <= m_cnt + 3; m_fired <= 1;
         end else begin
            m_cnt <= (m_cnt + 1) % 64;
            if (m_cnt == 63) m_fired <= 0;
         end
      end
   end

   // continuous comparison a quarter period after each rising edge
   always @(posedge clk) begin
      #(CLK_P/4);
      if (rst_n && !done) begin
         bit er, ed;
         er = (m_cnt >= 32);
         ed = dec_rec_sel ? er : rx_clk_in;
         chk(rec_clk == er, "R4", rec_clk, er);
         chk(dec_clk == ed, "R7", dec_clk, ed);
         if (enc_sel == 2'b01) chk(enc_clk == (m_int >= 32), "R9", enc_clk, m_int >= 32);
         else chk(enc_clk == f_enc(enc_sel, tx_clk_in, ed, m_int >= 32), "R8", enc_clk,
                  f_enc(enc_sel, tx_clk_in, ed, m_int >= 32));
      end
   end

   task automatic fire(input int mode);
      case (mode)
         0: rx_data = ~rx_data;
         1: ref_clk_in = 1'b1;
         2: ref_stb_in = 1'b1;
         default: begin rx_data = ~rx_data; ref_stb_in = 1'b1; end
      endcase
   endtask

   // time from a rec_clk rise (count 32) to the second following rise
   task automatic span_case(input int mode, input int d, input int d2, input int exp, input string req);
      int n = 0;
      int rises = 0;
      bit last = 1'b1;
      ref_clk_in = 1'b0;
      ref_stb_in = 1'b0;
      @(negedge clk);
      while (rec_clk !== 1'b0) @(negedge clk);
      while (rec_clk !== 1'b1) @(negedge clk);
      while (rises < 2 && n < 400) begin
         if (n == d)  fire(mode);
         if (n == d2) fire(mode);
         @(negedge clk);
         n++;
         if (rec_clk && !last) rises++;
         last = rec_clk;
      end
      chk(n == exp, req, n, exp);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(rec_clk == 1'b0, "R1", rec_clk, 0);
      chk(enc_clk == 1'b0, "R1", enc_clk, 0);
      rst_n = 1'b1;
      repeat (31) @(posedge clk);
      #1;
      chk(rec_clk == 1'b0, "R1", rec_clk, 0);
      chk(enc_clk == 1'b0, "R1", enc_clk, 0);
      @(posedge clk);
      #1;
      chk(rec_clk == 1'b1, "R1", rec_clk, 1);
      chk(enc_clk == 1'b1, "R1", enc_clk, 1);
      @(negedge clk);

      // R2: tracking off ignores a late edge
      trk_en = 0; ref_ext = 1; ref_stb_sel = 0;
      span_case(1, 14, -1, 128, "R2");
      trk_en = 1;
      // R4: late edge (count 48) retards, early edge (count 16) advances
      span_case(1, 14, -1, 130, "R4");
      span_case(1, 46, -1, 126, "R4");
      // R5: dead band edges at counts 31 and 33, outside at 30 and 34
      span_case(1, 61, -1, 128, "R5");
      span_case(1, 63, -1, 128, "R5");
      span_case(1, 60, -1, 126, "R5");
      span_case(1, 0, -1, 130, "R5");
      // R3: unselected inputs ignored, strobe and data selections heard
      span_case(3, 14, -1, 128, "R3");
      ref_stb_sel = 1;
      span_case(2, 14, -1, 130, "R3");
      ref_ext = 0;
      span_case(0, 14, -1, 130, "R3");
      // R6: second edge in the same period is ignored
      span_case(0, 14, 20, 130, "R6");

      // R7 / R8: directed routing
      for (int s = 0; s < 4; s++) begin
         for (int v = 0; v < 2; v++) begin
            @(negedge clk);
            enc_sel = s[1:0]; dec_rec_sel = 1'b0; rx_clk_in = v[0]; tx_clk_in = ~v[0];
            #1;
            chk(dec_clk == v[0], "R7", dec_clk, v);
            chk(enc_clk == f_enc(s[1:0], ~v[0], v[0], 1'b0) || s == 1, "R8", enc_clk,
                f_enc(s[1:0], ~v[0], v[0], 1'b0));
         end
      end
      dec_rec_sel = 1'b1;

      // constrained random phase
      for (int i = 0; i < 30000; i++) begin
         @(negedge clk);
         if ($urandom_range(0, 39) == 0) rx_data = ~rx_data;
         if ($urandom_range(0, 29) == 0) ref_clk_in = ~ref_clk_in;
         if ($urandom_range(0, 29) == 0) ref_stb_in = ~ref_stb_in;
         rx_clk_in = $urandom_range(0, 1);
         tx_clk_in = $urandom_range(0, 1);
         if (i % 700 == 0) begin
            trk_en      = ($urandom_range(0, 3) != 0);
            ref_ext     = $urandom_range(0, 1);
            ref_stb_sel = $urandom_range(0, 1);
            dec_rec_sel = $urandom_range(0, 1);
            enc_sel     = 2'($urandom_range(0, 3));
         end
      end
      @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

endmodule